// File: doc/BRIEF.md
# Timer Master Trigger Output Selector

This block picks one internal timer event and drives it onto a single trigger line. Slave timers and data converters use that line to stay in step with this timer. A 4-bit mode code chooses the source. The candidates are:

- the software update-generation strobe
- the counter-enable condition
- the update event
- a pulse for each channel-1 capture/compare event
- one of four compare reference levels
- the encoder clock

The chosen source passes through one flip-flop, so the trigger line follows its source one clock later. That register is also why a reset raised by the trigger input in reset slave mode shows up on the line after the reset itself.

The encoder-clock selection is meaningful only while the slave-mode controller runs in one of the modes that produce an encoder clock. If the encoder clock is chosen with any other slave mode, the line is held low and a registered illegal-configuration flag is raised. Mode codes with no assigned source are silent: the line stays low and the flag stays clear.

Top module: `trgo_select`

## Requirements
- R1: While `rst_n` is low, `trgo` and `cfg_illegal` are 0. Reset is asynchronous, so both outputs drop as soon as `rst_n` falls.
- R2: With mode code 4'b0000, `trgo` equals `sw_update` from the previous clock.
- R3: With mode code 4'b0001, `trgo` is `cnt_enable` ANDed with the gate term from the previous clock. The gate term is `trig_in` when `gated_mode` is 1, and 1 when `gated_mode` is 0.
- R4: With mode code 4'b0010, `trgo` equals `update_evt` from the previous clock.
- R5: With mode code 4'b0011, `trgo` is high in the cycle after every cycle in which `cc1_evt` is high. Back-to-back events give back-to-back high cycles, with no edge detection.
- R6: With mode codes 4'b0100 to 4'b0111, `trgo` follows `oc_ref[0]` to `oc_ref[3]` respectively, one clock late.
- R7: With mode code 4'b1000 and `slave_mode` equal to 4'b0001, 4'b0010, 4'b0011 or any value from 4'b1010 to 4'b1111, `trgo` follows `enc_clk` one clock late and `cfg_illegal` is 0.
- R8: With mode code 4'b1000 and any other `slave_mode` value, `trgo` is 0 and `cfg_illegal` is 1 in the following cycle.
- R9: With mode codes 4'b1001 to 4'b1111, `trgo` and `cfg_illegal` are 0 whatever the other inputs do.
- R10: Every source reaches `trgo` with exactly one clock of latency. A change on a source input is not visible before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_code | input | 4 | Trigger source selection code |
| slave_mode | input | 4 | Current slave-mode controller code |
| sw_update | input | 1 | Software update-generation strobe |
| cnt_enable | input | 1 | Counter enable control bit |
| gated_mode | input | 1 | Slave controller is in gated mode |
| trig_in | input | 1 | Trigger input level used for gating |
| update_evt | input | 1 | Update event strobe |
| cc1_evt | input | 1 | Channel-1 capture or compare event strobe |
| oc_ref | input | 4 | Compare reference levels, channel 1 in bit 0 |
| enc_clk | input | 1 | Encoder clock |
| trgo | output | 1 | Registered trigger output |
| cfg_illegal | output | 1 | Registered encoder/slave-mode mismatch flag |

## Verification
The assertions take every input as synchronous to `clk` and settled at each rising edge. They also take the inputs as known (not X) from the first edge after reset releases, because each check compares `trgo` with the sampled source of the previous edge. The stimulus keeps within this: every input is driven to a defined value from time zero, changes only at falling clock edges, and is sampled shortly after rising edges. That includes the mode and slave-mode sweeps and the deliberate reset in the middle of the run.

// File: rtl/trgo_select_pkg.sv
package trgo_select_pkg;

    localparam int MODE_W = 4;
    localparam int SMS_W  = 4;

    // Mode codes with an assigned source; every other value is reserved
    typedef enum logic [MODE_W-1:0] {
        MD_SW_UPDATE  = 4'd0,
        MD_CNT_ENABLE = 4'd1,
        MD_UPDATE     = 4'd2,
        MD_CC1_PULSE  = 4'd3,
        MD_REF_FIRST  = 4'd4,
        MD_ENC_CLOCK  = 4'd8
    } trgo_mode_e;

    // Bit positions inside the source vector
    localparam int SRC_SW   = 0;
    localparam int SRC_CEN  = 1;
    localparam int SRC_UPD  = 2;
    localparam int SRC_CC1  = 3;
    localparam int SRC_REF0 = 4;

    // Slave modes under which an encoder clock exists
    function automatic logic enc_mode_allowed(input logic [SMS_W-1:0] sms);
        logic ok;
        unique case (sms)
            4'b0001, 4'b0010, 4'b0011: ok = 1'b1;
            4'b1010, 4'b1011, 4'b1100,
            4'b1101, 4'b1110, 4'b1111: ok = 1'b1;
            default:                   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/trgo_select_sources.sv
module trgo_select_sources
    import trgo_select_pkg::*;
#(
    parameter int NUM_REF = 4,
    localparam int NSRC   = SRC_REF0 + NUM_REF + 1
) (
    input  logic               sw_update,
    input  logic               cnt_enable,
    input  logic               gated_mode,
    input  logic               trig_in,
    input  logic               update_evt,
    input  logic               cc1_evt,
    input  logic [NUM_REF-1:0] oc_ref,
    input  logic               enc_clk,
    output logic [NSRC-1:0]    src
);

    logic gate_term;

    // The trigger input gates the enable only in gated slave mode
    assign gate_term = gated_mode ? trig_in : 1'b1;

    assign src[SRC_SW]  = sw_update;
    assign src[SRC_CEN] = cnt_enable & gate_term;
    assign src[SRC_UPD] = update_evt;
    // Every event strobe is a pulse, whether or not a flag is already set
    assign src[SRC_CC1] = cc1_evt;

    for (genvar i = 0; i < NUM_REF; i++) begin : g_ref
        assign src[SRC_REF0 + i] = oc_ref[i];
    end

    assign src[NSRC-1] = enc_clk;

endmodule

// File: rtl/trgo_select_decode.sv
module trgo_select_decode
    import trgo_select_pkg::*;
#(
    parameter int NUM_REF = 4,
    localparam int NSRC   = SRC_REF0 + NUM_REF + 1
) (
    input  logic [MODE_W-1:0] mode_code,
    input  logic [SMS_W-1:0]  slave_mode,
    output logic [NSRC-1:0]   sel,
    output logic              enc_bad
);

    trgo_mode_e mode_e;

    assign mode_e = trgo_mode_e'(mode_code);

    always_comb begin
        sel     = '0;
        enc_bad = 1'b0;
        case (mode_e)
            MD_SW_UPDATE:  sel[SRC_SW]  = 1'b1;
            MD_CNT_ENABLE: sel[SRC_CEN] = 1'b1;
            MD_UPDATE:     sel[SRC_UPD] = 1'b1;
            MD_CC1_PULSE:  sel[SRC_CC1] = 1'b1;
            MD_ENC_CLOCK: begin
                if (enc_mode_allowed(slave_mode)) begin
                    sel[NSRC-1] = 1'b1;
                end else begin
                    enc_bad = 1'b1;
                end
            end
            default: ;
        endcase
        // Compare reference codes sit consecutively from the first ref code
        for (int i = 0; i < NUM_REF; i++) begin
            if (mode_code == MODE_W'(int'(MD_REF_FIRST) + i)) begin
                sel[SRC_REF0 + i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/trgo_select.sv
module trgo_select
    import trgo_select_pkg::*;
#(
    parameter int NUM_REF = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MODE_W-1:0]  mode_code,
    input  logic [SMS_W-1:0]   slave_mode,
    input  logic               sw_update,
    input  logic               cnt_enable,
    input  logic               gated_mode,
    input  logic               trig_in,
    input  logic               update_evt,
    input  logic               cc1_evt,
    input  logic [NUM_REF-1:0] oc_ref,
    input  logic               enc_clk,
    output logic               trgo,
    output logic               cfg_illegal
);

    localparam int NSRC = SRC_REF0 + NUM_REF + 1;

    logic [NSRC-1:0] src;
    logic [NSRC-1:0] sel;
    logic            enc_bad;
    logic            trg_d;

    trgo_select_sources #(.NUM_REF(NUM_REF)) u_sources (
        .sw_update  (sw_update),
        .cnt_enable (cnt_enable),
        .gated_mode (gated_mode),
        .trig_in    (trig_in),
        .update_evt (update_evt),
        .cc1_evt    (cc1_evt),
        .oc_ref     (oc_ref),
        .enc_clk    (enc_clk),
        .src        (src)
    );

    trgo_select_decode #(.NUM_REF(NUM_REF)) u_decode (
        .mode_code  (mode_code),
        .slave_mode (slave_mode),
        .sel        (sel),
        .enc_bad    (enc_bad)
    );

    // One-hot AND-OR selection; an all-zero select gives a low line
    assign trg_d = |(src & sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trgo        <= 1'b0;
            cfg_illegal <= 1'b0;
        end else begin
            trgo        <= trg_d;
            cfg_illegal <= enc_bad;
        end
    end

endmodule

// File: rtl/trgo_select_checker.sv
module trgo_select_checker #(
    parameter int NUM_REF = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [3:0]         mode_code,
    input logic [3:0]         slave_mode,
    input logic               sw_update,
    input logic               cnt_enable,
    input logic               gated_mode,
    input logic               trig_in,
    input logic               update_evt,
    input logic               cc1_evt,
    input logic [NUM_REF-1:0] oc_ref,
    input logic               enc_clk,
    input logic               trgo,
    input logic               cfg_illegal
);

    logic past_ok;
    logic rst_seen;
    logic sms_good;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    always_ff @(posedge clk) rst_seen <= !rst_n;

    assign sms_good = (slave_mode >= 4'd1 && slave_mode <= 4'd3) || (slave_mode >= 4'd10);

    always @(posedge clk) begin
        if (!rst_n && rst_seen) begin
            AST_RESET_QUIET: assert (!trgo && !cfg_illegal); // R1
        end
    end

    AST_SW_UPDATE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(mode_code) == 4'd0 |-> trgo == $past(sw_update)); // R2

    AST_CNT_ENABLE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(mode_code) == 4'd1 |->
        trgo == ($past(cnt_enable) && (!$past(gated_mode) || $past(trig_in)))); // R3

    AST_UPDATE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(mode_code) == 4'd2 |-> trgo == $past(update_evt)); // R4

    AST_CC1_REPULSE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(mode_code) == 4'd3 |-> trgo == $past(cc1_evt)); // R5

    for (genvar i = 0; i < NUM_REF; i++) begin : g_ref_chk
        AST_REF_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && $past(mode_code) == 4'(4 + i) |-> trgo == $past(oc_ref[i])); // R6
    end

    AST_ENC_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(mode_code) == 4'd8 && $past(sms_good) |->
        !cfg_illegal && trgo == $past(enc_clk)); // R7

    AST_ENC_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(mode_code) == 4'd8 && !$past(sms_good) |->
        cfg_illegal && !trgo); // R8

    AST_RESERVED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(mode_code) >= 4'd9 |-> !trgo && !cfg_illegal); // R9

    AST_FLAG_NEEDS_ENC: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_illegal |-> past_ok && $past(mode_code) == 4'd8); // R8

endmodule

bind trgo_select trgo_select_checker #(.NUM_REF(NUM_REF)) u_chk (.*);

// File: tb/trgo_select_bench.sv
`timescale 1ns/1ps
module trgo_select_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mode_code = '0;
    logic [3:0] slave_mode = '0;
    logic       sw_update = 1'b0;
    logic       cnt_enable = 1'b0;
    logic       gated_mode = 1'b0;
    logic       trig_in = 1'b0;
    logic       update_evt = 1'b0;
    logic       cc1_evt = 1'b0;
    logic [3:0] oc_ref = '0;
    logic       enc_clk = 1'b0;
    logic       trgo;
    logic       cfg_illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    trgo_select u_trgo_select (
        .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .slave_mode(slave_mode),
        .sw_update(sw_update), .cnt_enable(cnt_enable), .gated_mode(gated_mode),
        .trig_in(trig_in), .update_evt(update_evt), .cc1_evt(cc1_evt),
        .oc_ref(oc_ref), .enc_clk(enc_clk), .trgo(trgo), .cfg_illegal(cfg_illegal)
    );

    // Vector: mode[20:17] sms[16:13] ug[12] cen[11] gated[10] trig[9]
    //         upd[8] cc1[7] ocref[6:3] enc[2] exp_trgo[1] exp_flag[0]
    localparam int NV = 23;
    localparam logic [20:0] VEC [NV] = '{
        {4'h0, 4'h0, 6'b100000, 4'h0, 1'b0, 2'b10},  // R2
        {4'h0, 4'h0, 6'b010011, 4'hF, 1'b1, 2'b00},  // R2
        {4'h1, 4'h0, 6'b010000, 4'h0, 1'b0, 2'b10},  // R3
        {4'h1, 4'h0, 6'b011000, 4'h0, 1'b0, 2'b00},  // R3
        {4'h1, 4'h0, 6'b011100, 4'h0, 1'b0, 2'b10},  // R3
        {4'h1, 4'h0, 6'b000100, 4'h0, 1'b0, 2'b00},  // R3
        {4'h2, 4'h0, 6'b000010, 4'h0, 1'b0, 2'b10},  // R4
        {4'h2, 4'h0, 6'b110001, 4'hF, 1'b1, 2'b00},  // R4
        {4'h3, 4'h0, 6'b000001, 4'h0, 1'b0, 2'b10},  // R5
        {4'h3, 4'h0, 6'b000001, 4'h0, 1'b0, 2'b10},  // R5
        {4'h3, 4'h0, 6'b110010, 4'hF, 1'b1, 2'b00},  // R5
        {4'h4, 4'h0, 6'b000000, 4'h1, 1'b0, 2'b10},  // R6
        {4'h5, 4'h0, 6'b111111, 4'hD, 1'b1, 2'b00},  // R6
        {4'h6, 4'h0, 6'b000000, 4'h4, 1'b0, 2'b10},  // R6
        {4'h7, 4'h0, 6'b000000, 4'h8, 1'b0, 2'b10},  // R6
        {4'h7, 4'h0, 6'b111111, 4'h7, 1'b1, 2'b00},  // R6
        {4'h8, 4'h1, 6'b000000, 4'h0, 1'b1, 2'b10},  // R7
        {4'h8, 4'hA, 6'b111111, 4'hF, 1'b0, 2'b00},  // R7
        {4'h8, 4'hF, 6'b000000, 4'h0, 1'b1, 2'b10},  // R7
        {4'h8, 4'h0, 6'b111111, 4'hF, 1'b1, 2'b01},  // R8
        {4'h8, 4'h7, 6'b111111, 4'hF, 1'b1, 2'b01},  // R8
        {4'h9, 4'h1, 6'b111111, 4'hF, 1'b1, 2'b00},  // R9
        {4'hF, 4'h1, 6'b111111, 4'hF, 1'b1, 2'b00}   // R9
    };
    localparam int VREQ [NV] = '{2,2,3,3,3,3,4,4,5,5,5,6,6,6,6,6,7,7,7,8,8,9,9};

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic drive(input logic [20:0] v);
        mode_code  = v[20:17];
        slave_mode = v[16:13];
        sw_update  = v[12];
        cnt_enable = v[11];
        gated_mode = v[10];
        trig_in    = v[9];
        update_evt = v[8];
        cc1_evt    = v[7];
        oc_ref     = v[6:3];
        enc_clk    = v[2];
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: outputs quiet while reset is held
        repeat (3) @(posedge clk);
        #1;
        check("R1", trgo, 1'b0, "trgo in reset");
        check("R1", cfg_illegal, 1'b0, "flag in reset");
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: drive at falling edge, sample 1 ns after the next rising edge
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(VEC[k]);
            @(posedge clk);
            #1;
            check($sformatf("R%0d", VREQ[k]), trgo, VEC[k][1], $sformatf("trgo vec %0d", k));
            check($sformatf("R%0d", VREQ[k]), cfg_illegal, VEC[k][0], $sformatf("flag vec %0d", k));
        end

        // R10: a source change is invisible until the next rising edge
        @(negedge clk);
        drive({4'h2, 4'h0, 6'b000000, 4'h0, 1'b0, 2'b00});
        @(negedge clk);
        update_evt = 1'b1;
        #1;
        check("R10", trgo, 1'b0, "trgo before edge (rise)");
        @(posedge clk);
        #1;
        check("R10", trgo, 1'b1, "trgo after edge (rise)");
        @(negedge clk);
        update_evt = 1'b0;
        #1;
        check("R10", trgo, 1'b1, "trgo before edge (fall)");
        @(posedge clk);
        #1;
        check("R10", trgo, 1'b0, "trgo after edge (fall)");

        // R7 and R8: every slave mode with the encoder code
        for (int s = 0; s < 16; s++) begin
            logic legal;
            legal = (s >= 1 && s <= 3) || (s >= 10);
            @(negedge clk);
            drive({4'h8, 4'(s), 6'b000000, 4'h0, 1'b1, 2'b00});
            @(posedge clk);
            #1;
            check(legal ? "R7" : "R8", trgo, legal, $sformatf("trgo sms %0d", s));
            check(legal ? "R7" : "R8", cfg_illegal, !legal, $sformatf("flag sms %0d", s));
        end

        // R9: every reserved code with all sources high
        for (int c = 9; c < 16; c++) begin
            @(negedge clk);
            drive({4'(c), 4'h0, 6'b111111, 4'hF, 1'b1, 2'b00});
            @(posedge clk);
            #1;
            check("R9", trgo, 1'b0, $sformatf("trgo code %0d", c));
            check("R9", cfg_illegal, 1'b0, $sformatf("flag code %0d", c));
        end

        // R1: reset in mid-run clears a raised flag and a high line at once
        @(negedge clk);
        drive({4'h8, 4'h0, 6'b000000, 4'h0, 1'b1, 2'b00});
        @(posedge clk);
        #1;
        check("R8", cfg_illegal, 1'b1, "flag before mid reset");
        @(negedge clk);
        drive({4'h2, 4'h0, 6'b000010, 4'h0, 1'b0, 2'b00});
        @(posedge clk);
        #1;
        check("R4", trgo, 1'b1, "trgo before mid reset");
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", trgo, 1'b0, "trgo async reset");
        check("R1", cfg_illegal, 1'b0, "flag async reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R4", trgo, 1'b1, "trgo after reset release");

        finish_run();
    end

endmodule